// File: doc/BRIEF.md
# Power and Reset Control Unit

This block is the chip-wide power and reset controller that sits behind a byte-wide register port, as it would behind a serial-bus slave's register file. It decides whether power-down is driven by an external pin or by a register bit. From that choice it produces a clock enable for the core logic and a low-current indication for the analog section. The register file itself is never gated, so configuration survives power-down and the host can still reach it.

Writing the soft-reset bit has the same effect as the external reset pin. Every register with a defined default is restored, and a busy window of a parameterised length begins. During that window host accesses are refused, and when it ends a one-cycle restart pulse tells the core to begin acquisition. The block also turns two register bits into output-enable levels: one for the pixel data and timing outputs, with a separate override that keeps the timing outputs driven, and one for the line-locked clock output.

The external reset pin takes effect asynchronously and is released through a two-stage synchronizer. The busy window starts counting once that release has passed the synchronizer.

Top module: `power_reset_ctrl`

## Requirements
- R1: While the source-select bit (address 0x0F bit 2) is 0, power-down follows `pdPin` two clock edges after the pin changes, and the register power-down bit (0x0F bit 5) has no effect.
- R2: While the source-select bit is 1, power-down follows 0x0F bit 5 from the clock edge that writes it, and `pdPin` has no effect.
- R3: In power-down `coreClkEn` is 0 and `analogLowCurrent` is 1. Host reads and writes are still acknowledged, and register contents are kept.
- R4: A write to 0x0F with bit 7 set stores none of its other bits. At that edge every defaulted field returns to 0, which ends any power-down requested through a register, and 0x0F then reads back with bit 7 equal to 0.
- R5: Address 0x1D bits 3:0 have no default. Both soft reset and pin reset leave them holding their last written value.
- R6: `resetBusy` is 1 for exactly RESET_CYCLES cycles after the soft-reset write edge. While it is 1, `hostAck` is 0 and refused writes change nothing.
- R7: `coreRestart` is 1 for exactly one cycle, the first cycle in which `resetBusy` is 0 after a reset sequence.
- R8: `rstPinN` low sets `resetBusy` without waiting for a clock edge. `resetBusy` falls RESET_CYCLES+2 rising edges after the pin is released.
- R9: Address 0x03 bit 6 set drives `dataOe` to 0 and `timingOe` to 0, unless 0x03 bit 3 is also set, in which case `timingOe` stays 1. Both bits default to 0.
- R10: Address 0x1D bit 7 set drives `llcOe` to 0. The default is 0.
- R11: Reads of any address other than 0x03, 0x0F and 0x1D return 0, and writes to those addresses are ignored. Bits that are not implemented read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPinN | input | 1 | External reset, active low, asserted asynchronously |
| pdPin | input | 1 | External power-down request, active high |
| hostValid | input | 1 | Host access strobe, one cycle per access |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 8 | Register address |
| hostWdata | input | 8 | Write data |
| hostAck | output | 1 | Access accepted in this cycle (0 = refused) |
| hostRdata | output | 8 | Read data, valid while hostAck is 1 |
| resetBusy | output | 1 | Reset sequence in progress |
| coreRestart | output | 1 | One-cycle pulse when the reset sequence ends |
| coreClkEn | output | 1 | Clock enable for the core logic |
| analogLowCurrent | output | 1 | Low-current mode request for analog blocks |
| dataOe | output | 1 | Output enable for pixel data and the field-start line |
| timingOe | output | 1 | Output enable for the sync and field outputs |
| llcOe | output | 1 | Output enable for the line-locked clock output |

## Verification
Two functions can fall on the same clock edge: ending a power-down that a register requested, and starting a soft reset. A single write to 0x0F sets the soft-reset bit together with the power-down and source-select bits, and this triggers both. The bench then requires the restored defaults to win: in the cycle after that edge the core clock is enabled, the busy window has started, and none of the other written bits are stored. Host accesses are also issued inside a busy window. The bench checks that they are refused and, after the window closes, that the registers they targeted are unchanged.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 8;
  localparam int TAG_W  = 4;

  localparam logic [REG_AW-1:0] ADDR_GLOBAL = 8'h0F;
  localparam logic [REG_AW-1:0] ADDR_OUTCTL = 8'h03;
  localparam logic [REG_AW-1:0] ADDR_CLKCTL = 8'h1D;

  localparam int BIT_SRCSEL   = 2;
  localparam int BIT_PDREQ    = 5;
  localparam int BIT_SOFTRST  = 7;
  localparam int BIT_OUTTRI   = 6;
  localparam int BIT_TIMFORCE = 3;
  localparam int BIT_LLCTRI   = 7;

  // strobes from control to register datapath
  typedef struct packed {
    logic wrEn;
    logic loadDefaults;
  } regStrobe_t;

  // decoded control fields exported by the register datapath
  typedef struct packed {
    logic srcSel;
    logic pdReq;
    logic outTri;
    logic timForce;
    logic llcTri;
  } ctrlBits_t;
endpackage

// File: rtl/pmu_sync.sv
module pmu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pmu_seq.sv
module pmu_seq
  import pmu_pkg::*;
#(
  parameter int RESET_CYCLES = 250000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstPinN,
  input  logic              pdPin,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [REG_AW-1:0] hostAddr,
  input  logic [REG_DW-1:0] hostWdata,
  output logic              rstN,
  output regStrobe_t        strobe,
  output logic              hostAck,
  output logic              busy,
  output logic              coreRestart,
  output logic              pdPinSync
);
  localparam int CNT_W = $clog2(RESET_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESET_CYCLES);

  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             wrAccept;
  logic             softHit;

  pmu_sync #(.STAGES(SYNC_STAGES)) uRstSync (
    .clk(clk), .rstN(rstPinN), .d(1'b1), .q(rstN)
  );

  pmu_sync #(.STAGES(SYNC_STAGES)) uPdSync (
    .clk(clk), .rstN(rstN), .d(pdPin), .q(pdPinSync)
  );

  assign busy     = (cnt != '0);
  assign accept   = hostValid && !busy;
  assign wrAccept = accept && hostWrite;
  assign softHit  = wrAccept && (hostAddr == ADDR_GLOBAL) && hostWdata[BIT_SOFTRST];
  assign hostAck  = accept;

  assign strobe.wrEn         = wrAccept && !softHit;
  assign strobe.loadDefaults = softHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= CNT_LOAD;
    else if (softHit)      cnt <= CNT_LOAD;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) coreRestart <= 1'b0;
    else       coreRestart <= (cnt == CNT_W'(1)) && !softHit;
  end

  // R6: refused while busy
  p_refuse_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostValid) |-> !hostAck);
  // R6: soft reset opens a busy window
  p_soft_opens_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDefaults |=> busy);
  // R7: restart pulse lasts one cycle
  p_restart_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    coreRestart |=> !coreRestart);
  // R7: end of busy comes with restart
  p_restart_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> coreRestart);
endmodule

// File: rtl/pmu_regfile.sv
module pmu_regfile
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [REG_AW-1:0] hostAddr,
  input  logic [REG_DW-1:0] hostWdata,
  output logic [REG_DW-1:0] rdata,
  output ctrlBits_t         ctrl
);
  ctrlBits_t        regs;
  logic [TAG_W-1:0] userTag;
  logic             knownAddr;

  assign knownAddr = (hostAddr == ADDR_GLOBAL) || (hostAddr == ADDR_OUTCTL) ||
                     (hostAddr == ADDR_CLKCTL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs <= '0;
    end else if (strobe.loadDefaults) begin
      regs <= '0;
    end else if (strobe.wrEn) begin
      case (hostAddr)
        ADDR_GLOBAL: begin
          regs.srcSel <= hostWdata[BIT_SRCSEL];
          regs.pdReq  <= hostWdata[BIT_PDREQ];
        end
        ADDR_OUTCTL: begin
          regs.outTri   <= hostWdata[BIT_OUTTRI];
          regs.timForce <= hostWdata[BIT_TIMFORCE];
        end
        ADDR_CLKCTL: regs.llcTri <= hostWdata[BIT_LLCTRI];
        default: ;
      endcase
    end
  end

  // field without a default: untouched by either reset
  always_ff @(posedge clk) begin
    if (strobe.wrEn && (hostAddr == ADDR_CLKCTL))
      userTag <= hostWdata[TAG_W-1:0];
  end

  always_comb begin
    rdata = '0;
    case (hostAddr)
      ADDR_GLOBAL: begin
        rdata[BIT_SRCSEL] = regs.srcSel;
        rdata[BIT_PDREQ]  = regs.pdReq;
      end
      ADDR_OUTCTL: begin
        rdata[BIT_OUTTRI]   = regs.outTri;
        rdata[BIT_TIMFORCE] = regs.timForce;
      end
      ADDR_CLKCTL: begin
        rdata[BIT_LLCTRI]  = regs.llcTri;
        rdata[TAG_W-1:0]   = userTag;
      end
      default: ;
    endcase
  end

  assign ctrl = regs;

  // R4: defaults restored on soft reset
  p_defaults_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDefaults |=> (regs == '0));
  // R5: untouched field survives soft reset
  p_tag_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDefaults |=> (userTag == $past(userTag)));
  // R11: writes to unknown addresses change nothing
  p_unknown_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !knownAddr) |=> $stable(regs));
  // R4: soft reset bit never reads back as 1
  p_softbit_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == ADDR_GLOBAL) |-> !rdata[BIT_SOFTRST]);
endmodule

// File: rtl/power_reset_ctrl.sv
module power_reset_ctrl
  import pmu_pkg::*;
#(
  parameter int CLK_HZ       = 125_000_000,
  parameter int RESET_CYCLES = CLK_HZ / 500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstPinN,
  input  logic       pdPin,
  input  logic       hostValid,
  input  logic       hostWrite,
  input  logic [7:0] hostAddr,
  input  logic [7:0] hostWdata,
  output logic       hostAck,
  output logic [7:0] hostRdata,
  output logic       resetBusy,
  output logic       coreRestart,
  output logic       coreClkEn,
  output logic       analogLowCurrent,
  output logic       dataOe,
  output logic       timingOe,
  output logic       llcOe
);
  logic              rstN;
  logic              pdPinSync;
  logic              pdActive;
  regStrobe_t        strobe;
  ctrlBits_t         ctrl;
  logic [REG_DW-1:0] rdata;

  pmu_seq #(.RESET_CYCLES(RESET_CYCLES), .SYNC_STAGES(SYNC_STAGES)) uSeq (
    .clk(clk), .rstPinN(rstPinN), .pdPin(pdPin),
    .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .rstN(rstN), .strobe(strobe), .hostAck(hostAck),
    .busy(resetBusy), .coreRestart(coreRestart), .pdPinSync(pdPinSync)
  );

  pmu_regfile uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .rdata(rdata), .ctrl(ctrl)
  );

  assign pdActive         = ctrl.srcSel ? ctrl.pdReq : pdPinSync;
  assign coreClkEn        = !pdActive;
  assign analogLowCurrent = pdActive;
  assign dataOe           = !ctrl.outTri;
  assign timingOe         = !ctrl.outTri || ctrl.timForce;
  assign llcOe            = !ctrl.llcTri;
  assign hostRdata        = hostAck ? rdata : '0;

  // R1: with pin priority, register bit cannot move the clock enable
  p_reg_ignored_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.srcSel && $stable(ctrl.srcSel) && $stable(pdPinSync)) |-> $stable(coreClkEn));
  // R2: with register priority, the pin cannot move the clock enable
  p_pin_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.srcSel && $stable(ctrl.srcSel) && $stable(ctrl.pdReq)) |-> $stable(coreClkEn));
  // R3: clock gating and analog indication are complementary
  p_gate_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn != analogLowCurrent);
endmodule

// File: tb/sim_power_reset_ctrl.sv
module sim_power_reset_ctrl;
  localparam int N = 20;

  logic       clk = 1'b0;
  logic       rstPinN = 1'b0;
  logic       pdPin = 1'b0;
  logic       hostValid = 1'b0;
  logic       hostWrite = 1'b0;
  logic [7:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic       hostAck;
  logic [7:0] hostRdata;
  logic       resetBusy, coreRestart, coreClkEn, analogLowCurrent;
  logic       dataOe, timingOe, llcOe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit         expAck;
    bit         chkData;
    logic [7:0] expData;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  power_reset_ctrl #(.RESET_CYCLES(N)) u0 (
    .clk(clk), .rstPinN(rstPinN), .pdPin(pdPin),
    .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostAck(hostAck), .hostRdata(hostRdata),
    .resetBusy(resetBusy), .coreRestart(coreRestart),
    .coreClkEn(coreClkEn), .analogLowCurrent(analogLowCurrent),
    .dataOe(dataOe), .timingOe(timingOe), .llcOe(llcOe)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one access, expected response pushed to the scoreboard
  task automatic hostOp(input bit wr, input logic [7:0] a, input logic [7:0] d,
                        input bit expAck, input bit chk, input logic [7:0] expD,
                        input string tag);
    item_t it;
    @(negedge clk);
    hostValid = 1'b1; hostWrite = wr; hostAddr = a; hostWdata = d;
    it.expAck = expAck; it.chkData = chk; it.expData = expD; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    hostValid = 1'b0; hostWrite = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compares what the design returns with the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (hostValid) begin
        if (sbq.size() == 0) begin
          checks++; failures++;
          $display("FAIL scoreboard empty actual=1 expected=0");
        end else begin
          item_t it;
          it = sbq.pop_front();
          check(32'(hostAck), 32'(it.expAck), {it.tag, " ack"});
          if (it.chkData && it.expAck) check(32'(hostRdata), 32'(it.expData), {it.tag, " data"});
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int len;
    waitCycles(3);
    check(32'(resetBusy), 1, "R8 busy while pin reset held");
    check(32'(coreClkEn), 1, "R3 clock enabled at reset");
    check(32'({dataOe, timingOe, llcOe}), 3'b111, "R9 R10 enables at reset");
    hostOp(1'b0, 8'h0F, 8'h00, 1'b0, 1'b0, 8'h00, "R6 refused during pin reset");

    // R8: release timing
    @(negedge clk); rstPinN = 1'b1;
    repeat (N + 1) @(posedge clk);
    @(negedge clk);
    check(32'(resetBusy), 1, "R8 busy one edge before end");
    @(negedge clk);
    check(32'(resetBusy), 0, "R8 busy ends N+2 edges after release");
    check(32'(coreRestart), 1, "R7 restart pulse after pin reset");
    @(negedge clk);
    check(32'(coreRestart), 0, "R7 restart lasts one cycle");

    // R11 and field readback
    hostOp(1'b1, 8'h1D, 8'h05, 1'b1, 1'b0, 8'h00, "R5 write tag");
    hostOp(1'b0, 8'h1D, 8'h00, 1'b1, 1'b1, 8'h05, "R5 read tag");
    hostOp(1'b1, 8'h40, 8'hFF, 1'b1, 1'b0, 8'h00, "R11 write unknown");
    hostOp(1'b0, 8'h40, 8'h00, 1'b1, 1'b1, 8'h00, "R11 read unknown");
    hostOp(1'b0, 8'h0F, 8'h00, 1'b1, 1'b1, 8'h00, "R11 global untouched");
    hostOp(1'b0, 8'h03, 8'h00, 1'b1, 1'b1, 8'h00, "R11 outctl untouched");
    hostOp(1'b1, 8'h03, 8'hB7, 1'b1, 1'b0, 8'h00, "R11 write with spare bits");
    hostOp(1'b0, 8'h03, 8'h00, 1'b1, 1'b1, 8'h00, "R11 spare bits read 0");

    // R1: pin priority
    @(negedge clk); pdPin = 1'b1;
    @(negedge clk);
    check(32'(coreClkEn), 1, "R1 pin not yet through synchronizer");
    @(negedge clk);
    check(32'(coreClkEn), 0, "R1 pin power-down clock gated");
    check(32'(analogLowCurrent), 1, "R3 analog low current");
    hostOp(1'b1, 8'h0F, 8'h20, 1'b1, 1'b0, 8'h00, "R1 set reg bit");
    @(negedge clk); pdPin = 1'b0;
    waitCycles(3);
    check(32'(coreClkEn), 1, "R1 reg bit ignored under pin priority");
    hostOp(1'b0, 8'h0F, 8'h00, 1'b1, 1'b1, 8'h20, "R3 reg bit retained");

    // R2: register priority
    hostOp(1'b1, 8'h0F, 8'h24, 1'b1, 1'b0, 8'h00, "R2 select register");
    check(32'(coreClkEn), 0, "R2 register power-down immediate");
    @(negedge clk); pdPin = 1'b1;
    hostOp(1'b1, 8'h0F, 8'h04, 1'b1, 1'b0, 8'h00, "R2 clear reg bit");
    waitCycles(3);
    check(32'(coreClkEn), 1, "R2 pin ignored under register priority");
    @(negedge clk); pdPin = 1'b0;

    // R3 + R9: register access during power-down
    hostOp(1'b1, 8'h0F, 8'h24, 1'b1, 1'b0, 8'h00, "R3 enter power-down");
    hostOp(1'b1, 8'h03, 8'h48, 1'b1, 1'b0, 8'h00, "R3 write while powered down");
    hostOp(1'b0, 8'h03, 8'h00, 1'b1, 1'b1, 8'h48, "R3 read while powered down");
    check(32'({dataOe, timingOe}), 2'b01, "R9 timing forced on");
    hostOp(1'b1, 8'h03, 8'h40, 1'b1, 1'b0, 8'h00, "R9 drop force");
    check(32'({dataOe, timingOe}), 2'b00, "R9 all tri-stated");
    hostOp(1'b1, 8'h1D, 8'h85, 1'b1, 1'b0, 8'h00, "R10 llc tri");
    check(32'(llcOe), 0, "R10 llc disabled");
    hostOp(1'b0, 8'h1D, 8'h00, 1'b1, 1'b1, 8'h85, "R10 readback");

    // R4 + R6: soft reset coinciding with register power-down release
    hostOp(1'b1, 8'h0F, 8'hA4, 1'b1, 1'b0, 8'h00, "R4 soft reset with pd bits");
    check(32'(resetBusy), 1, "R6 busy after soft reset");
    check(32'(coreClkEn), 1, "R4 power-down ended by soft reset");
    check(32'({dataOe, timingOe, llcOe}), 3'b111, "R4 enables restored");
    len = 1;
    for (int i = 0; i < 4 * N; i++) begin
      @(negedge clk);
      if (!resetBusy) break;
      len++;
    end
    check(32'(len), 32'(N), "R6 busy length");
    check(32'(coreRestart), 1, "R7 restart after soft reset");
    hostOp(1'b0, 8'h0F, 8'h00, 1'b1, 1'b1, 8'h00, "R4 global reads zero");
    hostOp(1'b0, 8'h03, 8'h00, 1'b1, 1'b1, 8'h00, "R4 outctl default");
    hostOp(1'b0, 8'h1D, 8'h00, 1'b1, 1'b1, 8'h05, "R5 tag kept over soft reset");

    // R6: refusal during busy
    hostOp(1'b1, 8'h0F, 8'h80, 1'b1, 1'b0, 8'h00, "R6 second soft reset");
    hostOp(1'b1, 8'h03, 8'h40, 1'b0, 1'b0, 8'h00, "R6 write refused");
    hostOp(1'b0, 8'h1D, 8'h00, 1'b0, 1'b0, 8'h00, "R6 read refused");
    for (int i = 0; i < 4 * N; i++) begin
      @(negedge clk);
      if (!resetBusy) break;
    end
    check(32'(dataOe), 1, "R6 refused write had no effect");
    hostOp(1'b0, 8'h03, 8'h00, 1'b1, 1'b1, 8'h00, "R6 refused write not stored");

    // R5 + R8: pin reset keeps tag, asserts busy at once
    hostOp(1'b1, 8'h1D, 8'h0A, 1'b1, 1'b0, 8'h00, "R5 new tag");
    @(negedge clk); rstPinN = 1'b0;
    #1;
    check(32'(resetBusy), 1, "R8 busy asynchronous on pin");
    waitCycles(2);
    rstPinN = 1'b1;
    for (int i = 0; i < 4 * N; i++) begin
      @(negedge clk);
      if (!resetBusy) break;
    end
    hostOp(1'b0, 8'h1D, 8'h00, 1'b1, 1'b1, 8'h0A, "R5 tag kept over pin reset");

    waitCycles(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule